// File: doc/BRIEF.md
# Half-Band Interpolation Chain

This block raises the sample rate of a 16-bit complex (I and Q) stream by 1, 2, 4 or 8. Three identical half-band stages sit in series and each active stage doubles the rate. A stage that is not needed becomes a one-cycle pipeline register, so the chain's latency does not depend on the factor. Everything runs on one fast clock. The caller presents one input word every 2^F cycles, where F is the factor code, and the chain then delivers one output word on every cycle.

Each active stage is a polyphase filter. Its first output phase is the input sample aligned with the centre tap. Its second output phase is the interpolated point, built from six past inputs and three distinct constant coefficients. A zero-stuffing mode removes the filtering: each input is doubled, and saturated if needed, and a zero follows it. The factor and the mode are captured only while reset is held, so changing those inputs during a run has no effect until the next reset.

Top module: `hbi_interp`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_i and out_q clear to zero and every stage's delay line is flushed to zero. After reset, the outputs behave as if all earlier inputs had been zero.
- R2: The factor code F on factor_sel selects an interpolation of 2^F (0→1x, 1→2x, 2→4x, 3→8x). The input must arrive every 2^F cycles. Each input then gives exactly 2^F outputs, and in steady state out_valid stays high on every cycle.
- R3: Stage s (numbered 0 to 2) filters when F > s. Otherwise it passes its input through unchanged with a delay of one cycle. With F = 0 the output therefore equals the input.
- R4: In filter mode, an active stage that receives x[n] first emits x[n-3]. It then emits (3·(x[n]+x[n-5]) − 25·(x[n-1]+x[n-4]) + 150·(x[n-2]+x[n-3]) + 128) >> 8, using an arithmetic shift.
- R5: When stuff_only is 1, an active stage first emits 2·x[n] and then emits 0.
- R6: Every stage result saturates to the range −32768 to 32767 instead of wrapping.
- R7: An output appears on out_valid three clock edges after the edge that samples the matching in_valid, whatever the factor.
- R8: factor_sel and stuff_only are sampled only while rst_n is low. Changes to them during a run leave the output sequence unchanged.
- R9: The I and Q paths are processed identically and independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at the output sample rate |
| rst_n | input | 1 | Synchronous active-low reset; also captures the configuration |
| factor_sel | input | 2 | Interpolation factor code F; the factor is 2^F |
| stuff_only | input | 1 | 1 = zero insertion with doubling, no filtering |
| in_valid | input | 1 | Input strobe, one pulse every 2^F cycles |
| in_i | input | 16 | In-phase input, two's complement |
| in_q | input | 16 | Quadrature input, two's complement |
| out_valid | output | 1 | Output strobe |
| out_i | output | 16 | In-phase output, two's complement |
| out_q | output | 16 | Quadrature output, two's complement |

## Verification
The stage assertions assume that the input cadence matches the captured factor exactly. A stage must never see a new input while its interpolated phase is still waiting to be sent, and the bench's driver holds the strobe spacing at exactly 2^F cycles to keep to this. The assertions also assume that the configuration is constant between resets. The bench therefore changes factor_sel and stuff_only in the middle of a run only to show that they are ignored, and its expected sequence keeps using the values captured at the last reset.

// File: rtl/hbi_pkg.sv
// Package: shared constants for the half-band interpolation chain.
// Assumes the interpolated phase uses a symmetric 6-tap branch. The branch
// coefficients are twice the half-band taps, in Q8, and they sum to 1.0.
package hbi_pkg;
    localparam int BR_TAPS = 6;    // length of the interpolated polyphase branch
    localparam int CTR_IDX = 3;    // delay index aligned with the 0.5 centre tap
    localparam int FRAC    = 8;    // fractional bits of the branch coefficients
    localparam int C_OUTER = 3;    // taps 0 and 5
    localparam int C_MID   = -25;  // taps 1 and 4
    localparam int C_INNER = 150;  // taps 2 and 3
endpackage

// File: rtl/hbi_branch.sv
// Module: interpolated-phase branch of one half-band stage, for one channel.
// It is purely combinational. taps[0] is the newest sample. The result is
// rounded half-up and saturated to DW bits.
module hbi_branch #(
    parameter int DW = 16
) (
    input  logic [hbi_pkg::BR_TAPS-1:0][DW-1:0] taps,
    output logic [DW-1:0]                       y
);
    import hbi_pkg::*;

    localparam int ACC_W = DW + 12;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC - 1));

    logic signed [ACC_W-1:0] ext [BR_TAPS];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rnd;

    // Sign-extend each tap to the accumulator width.
    for (genvar k = 0; k < BR_TAPS; k++) begin : g_ext
        assign ext[k] = ACC_W'($signed(taps[k]));
    end

    // Symmetric multiply-accumulate, then rounding and clamping.
    always_comb begin
        acc = ACC_W'(C_OUTER) * (ext[0] + ext[5])
            + ACC_W'(C_MID)   * (ext[1] + ext[4])
            + ACC_W'(C_INNER) * (ext[2] + ext[3]);
        rnd = (acc + HALF) >>> FRAC;
        if (rnd > MAXV)
            y = {1'b0, {(DW-1){1'b1}}};
        else if (rnd < MINV)
            y = {1'b1, {(DW-1){1'b0}}};
        else
            y = rnd[DW-1:0];
    end
endmodule

// File: rtl/hbi_stage.sv
// Module: one x2 half-band interpolation stage for I and Q.
// It assumes that in_valid pulses exactly every 2*gap cycles while en is high.
// On each input it emits the centre-aligned phase on the next cycle and the
// interpolated phase gap cycles after the input. With en low it is a
// one-cycle register. With stuff high it emits the input doubled, then zero.
module hbi_stage #(
    parameter int DW    = 16,
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stuff,
    input  logic [GAP_W-1:0] gap,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_i,
    input  logic [DW-1:0]    in_q,
    output logic             out_valid,
    output logic [DW-1:0]    out_i,
    output logic [DW-1:0]    out_q
);
    import hbi_pkg::*;

    localparam int NCH = 2;

    logic [DW-1:0]    din  [NCH];
    logic [DW-1:0]    dout [NCH];
    logic             pend;
    logic             second;
    logic [GAP_W-1:0] cnt;
    logic             take;
    logic             emit;

    assign din[0] = in_i;
    assign din[1] = in_q;
    assign out_i  = dout[0];
    assign out_q  = dout[1];
    assign take   = en && in_valid;
    assign emit   = en && pend && (cnt == '0);

    // Sequence the two output phases and the bypass strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pend      <= 1'b0;
            second    <= 1'b0;
            cnt       <= '0;
        end else if (!en) begin
            out_valid <= in_valid;
            pend      <= 1'b0;
            second    <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
            pend      <= 1'b1;
            second    <= 1'b0;
            cnt       <= gap - 1'b1;
        end else if (emit) begin
            out_valid <= 1'b1;
            pend      <= 1'b0;
            second    <= 1'b1;
        end else begin
            out_valid <= 1'b0;
            if (pend) cnt <= cnt - 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [BR_TAPS-1:0][DW-1:0] dly;
        logic [BR_TAPS-1:0][DW-1:0] dly_nxt;
        logic [DW-1:0]              fir;
        logic [DW-1:0]              dbl;
        logic [DW-1:0]              hold;

        assign dly_nxt = {dly[BR_TAPS-2:0], din[c]};

        hbi_branch #(.DW(DW)) u_branch (
            .taps (dly_nxt),
            .y    (fir)
        );

        // Double the input, saturating when the top two bits differ.
        always_comb begin
            if (din[c][DW-1] != din[c][DW-2])
                dbl = din[c][DW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
            else
                dbl = {din[c][DW-2:0], 1'b0};
        end

        // Shift the delay line and load the two phases per channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly     <= '0;
                hold    <= '0;
                dout[c] <= '0;
            end else if (!en) begin
                if (in_valid) dout[c] <= din[c];
            end else if (take) begin
                dly     <= dly_nxt;
                dout[c] <= stuff ? dbl : dly_nxt[CTR_IDX];
                hold    <= stuff ? '0 : fir;
            end else if (emit) begin
                dout[c] <= hold;
            end
        end
    end

    // R2: no new input may arrive while the interpolated phase is still waiting.
    a_r2_input_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pend) |-> !in_valid);

    // R5: in stuffing mode the second phase carries zero on both channels.
    a_r5_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stuff && out_valid && second) |-> (out_i == '0 && out_q == '0));

    // R6: doubling with saturation keeps the sign of the input.
    a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stuff && in_valid) |=>
        (out_i[DW-1] == $past(in_i[DW-1]) && out_q[DW-1] == $past(in_q[DW-1])));

    // R3: an inactive stage copies its input after one cycle.
    a_r3_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && in_valid) |=>
        (out_valid && out_i == $past(in_i) && out_q == $past(in_q)));
endmodule

// File: rtl/hbi_interp.sv
// Module: top of the selectable half-band interpolation chain.
// It captures the factor and the stuffing mode while reset is held. It then
// enables the first F stages and sets each stage's phase gap so that the
// chain delivers one output per clock.
module hbi_interp #(
    parameter int DW     = 16,
    parameter int STAGES = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(STAGES+1)-1:0]  factor_sel,
    input  logic                         stuff_only,
    input  logic                         in_valid,
    input  logic [DW-1:0]                in_i,
    input  logic [DW-1:0]                in_q,
    output logic                         out_valid,
    output logic [DW-1:0]                out_i,
    output logic [DW-1:0]                out_q
);
    localparam int FW    = $clog2(STAGES + 1);
    localparam int GAP_W = (STAGES > 1) ? STAGES : 1;

    logic [FW-1:0] factor_q;
    logic          stuff_q;
    logic          vld [STAGES+1];
    logic [DW-1:0] di  [STAGES+1];
    logic [DW-1:0] dq  [STAGES+1];

    // Capture the configuration only during reset (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            factor_q <= factor_sel;
            stuff_q  <= stuff_only;
        end
    end

    assign vld[0] = in_valid;
    assign di[0]  = in_i;
    assign dq[0]  = in_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic             st_en;
        logic [GAP_W-1:0] st_gap;

        // Enable and set the phase gap for this position in the chain.
        always_comb begin
            st_en  = int'(factor_q) > s;
            st_gap = st_en ? GAP_W'(1) << (int'(factor_q) - 1 - s) : GAP_W'(1);
        end

        hbi_stage #(.DW(DW), .GAP_W(GAP_W)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (st_en),
            .stuff     (stuff_q),
            .gap       (st_gap),
            .in_valid  (vld[s]),
            .in_i      (di[s]),
            .in_q      (dq[s]),
            .out_valid (vld[s+1]),
            .out_i     (di[s+1]),
            .out_q     (dq[s+1])
        );
    end

    assign out_valid = vld[STAGES];
    assign out_i     = di[STAGES];
    assign out_q     = dq[STAGES];

    // R1: the edge after a reset cycle shows an idle, zeroed output.
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && out_i == '0 && out_q == '0));
endmodule

// File: tb/hbi_interp_bench.sv
module hbi_interp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  factor_sel = 2'd0;
    logic        stuff_only = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic [15:0] out_i;
    logic [15:0] out_q;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_i[$];
    int exp_q[$];
    int hist [2][3][6];
    int cur_f = 0;
    bit cur_stuff = 0;
    string cur_req = "R3";
    int n_in = 0, n_out = 0, gaps = 0;
    int first_in = -1, first_out = -1, last_out = -1;
    bit done = 0;

    hbi_interp u_hbi_interp (
        .clk(clk), .rst_n(rst_n), .factor_sel(factor_sel), .stuff_only(stuff_only),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // One stage of the reference model for channel ch and stage s (R4, R5, R6).
    task automatic stage_model(input int ch, input int s, input int x, output int a, output int b);
        if (cur_stuff) begin
            a = sat16(2 * x);
            b = 0;
        end else begin
            int acc;
            for (int k = 5; k > 0; k--) hist[ch][s][k] = hist[ch][s][k-1];
            hist[ch][s][0] = x;
            a = hist[ch][s][3];
            acc = 3 * (hist[ch][s][0] + hist[ch][s][5])
                - 25 * (hist[ch][s][1] + hist[ch][s][4])
                + 150 * (hist[ch][s][2] + hist[ch][s][3]);
            b = sat16((acc + 128) >>> 8);
        end
    endtask

    task automatic expand(input int ch, input int x, ref int res[$]);
        int cur[$];
        int nxt[$];
        cur.push_back(x);
        for (int s = 0; s < cur_f; s++) begin
            nxt.delete();
            foreach (cur[j]) begin
                int a, b;
                stage_model(ch, s, cur[j], a, b);
                nxt.push_back(a);
                nxt.push_back(b);
            end
            cur = nxt;
        end
        res = cur;
    endtask

    // Driver: pushes expected outputs, then drives one input per 2^F cycles.
    task automatic send(input int xi, input int xq);
        int ri[$];
        int rq[$];
        int period;
        expand(0, xi, ri);
        expand(1, xq, rq);
        foreach (ri[k]) begin
            exp_i.push_back(ri[k]);
            exp_q.push_back(rq[k]);
        end
        period = 1 << cur_f;
        @(negedge clk);
        in_valid = 1'b1;
        in_i = 16'(xi);
        in_q = 16'(xq);
        if (first_in < 0) first_in = cyc;
        n_in++;
        if (period > 1) begin
            @(negedge clk);
            in_valid = 1'b0;
            repeat (period - 2) @(negedge clk);
        end
    endtask

    task automatic do_reset(input int f, input bit st, input string req);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        factor_sel = 2'(f);
        stuff_only = st;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_i == 16'd0 && out_q == 16'd0, "R1 data in reset", int'($signed(out_i)), 0);
        rst_n = 1'b1;
        cur_f = f;
        cur_stuff = st;
        cur_req = req;
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 3; s++)
                for (int k = 0; k < 6; k++) hist[c][s][k] = 0;
        n_in = 0; n_out = 0; gaps = 0;
        first_in = -1; first_out = -1; last_out = -1;
    endtask

    task automatic end_phase();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (16) @(negedge clk);
        check(exp_i.size() == 0, "R2 missing outputs", exp_i.size(), 0);
        check(n_out == (n_in << cur_f), "R2 output count", n_out, n_in << cur_f);
        check(gaps == 0, "R2 steady one output per cycle", gaps, 0);
        check(first_out - first_in == 3, "R7 latency", first_out - first_in, 3);
        exp_i.delete();
        exp_q.delete();
    endtask

    // Monitor: pops expected items and compares them to the outputs.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out++;
            if (first_out < 0) first_out = cyc;
            if (last_out >= 0 && cyc - last_out != 1) gaps++;
            last_out = cyc;
            if (exp_i.size() == 0) begin
                check(1'b0, "R2 unexpected output", int'($signed(out_i)), 0);
            end else begin
                int ei, eq;
                ei = exp_i.pop_front();
                eq = exp_q.pop_front();
                check(int'($signed(out_i)) == ei, cur_req, int'($signed(out_i)), ei);
                check(int'($signed(out_q)) == eq, "R9 Q path", int'($signed(out_q)), eq);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R3: factor 1, the output equals the input.
        do_reset(0, 0, "R3");
        send(1234, -77); send(-32768, 32767); send(32767, -32768); send(5, 6); send(-1, 0);
        end_phase();

        // R4: impulse through the x2 filter shows the centre and branch taps.
        do_reset(1, 0, "R4");
        send(10000, -10000);
        for (int k = 0; k < 7; k++) send(0, 0);
        end_phase();

        // R6: full-scale alternating pattern drives the branch into saturation.
        do_reset(1, 0, "R6");
        send(32767, -32768); send(-32768, 32767); send(32767, -32768);
        send(32767, -32768); send(-32768, 32767); send(32767, -32768);
        send(0, 0); send(0, 0); send(0, 0);
        end_phase();

        // R4 and R8: x4 ramp; the configuration changes mid-run and is ignored.
        do_reset(2, 0, "R8");
        for (int k = 0; k < 6; k++) send(k * 3000 - 9000, 4000 - k * 1500);
        factor_sel = 2'd3;
        stuff_only = 1'b1;
        for (int k = 0; k < 6; k++) send(k * 500, -k * 700);
        end_phase();

        // R4: x8 with a coarse sine-like sequence.
        do_reset(3, 0, "R4");
        send(0, 20000); send(14000, 14000); send(20000, 0); send(14000, -14000);
        send(0, -20000); send(-14000, -14000); send(-20000, 0); send(-14000, 14000);
        send(0, 0); send(0, 0);
        end_phase();

        // R5: x8 zero stuffing, including doubling saturation at both limits.
        do_reset(3, 1, "R5");
        send(16384, -16385); send(-32768, 32767); send(16383, -16384); send(-5, 7);
        end_phase();

        // R5: x2 zero stuffing.
        do_reset(1, 1, "R5");
        send(100, -100); send(-20000, 20000); send(0, 1);
        end_phase();

        // R1: fill the delay lines, then reset and check that the impulse starts clean.
        do_reset(1, 0, "R4");
        for (int k = 0; k < 5; k++) send(30000, -30000);
        end_phase();
        do_reset(1, 0, "R1");
        send(8000, 8000);
        for (int k = 0; k < 5; k++) send(0, 0);
        end_phase();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule